// File: doc/BRIEF.md
# Memory-Side Stall Buffer Pair

This block sits between user logic and a memory pipeline that never stops. A stall takes a few cycles to spread through the user logic, and the memory keeps returning read data during that time. The block holds both kinds of traffic so that nothing is lost. While the hold input is high, the block does two things. It captures the requests the user keeps issuing during the stall-spread window and keeps them away from the memory. It also captures every read word the memory returns, so that none reaches the stalled user.

When hold falls, each queue drains one entry per cycle, oldest first. Any new request or new read word that arrives while a queue still has entries joins the back of that queue. Traffic goes straight through, in the same cycle, only when the queue is empty. The input queue is sized to the stall-spread latency. The output queue is sized to the pipeline read latency plus that spread latency. If an entry arrives at a full queue that is not draining in that cycle, the entry is discarded and an error pulse is raised.

Top module: `stall_buffer`

## Requirements
- R1: After reset, mem_req_valid, usr_rd_valid and ovf_err are 0, and both queues are empty.
- R2: With hold low and the request queue empty, a user request appears on mem_req_valid/mem_req_data in the same cycle. With hold low and the read queue empty, a memory read word appears on usr_rd_valid/usr_rd_data in the same cycle.
- R3: While hold is high, mem_req_valid is 0 and each user request is stored in the request queue.
- R4: While hold is high, usr_rd_valid is 0 and each memory read word is stored in the read queue.
- R5: With hold low and the request queue not empty, the oldest stored request is issued each cycle. A new request that arrives in that time is queued behind the stored ones, so requests leave in the order they were issued.
- R6: With hold low and the read queue not empty, the oldest stored read word is delivered each cycle. New read words are queued behind the stored ones, so words leave in the order they arrived.
- R7: The request queue holds STALL_LAT entries and the read queue holds PIPE_LAT+STALL_LAT entries (2 and 8 by default) without loss.
- R8: An entry that arrives while its queue is full and not being drained in that cycle is dropped. ovf_err is then high for exactly the following cycle, and the stored entries are unchanged.
- R9: A push into a full queue in the same cycle as a drain pop is accepted and raises no ovf_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold | input | 1 | Stall is in effect: buffer traffic in both directions |
| usr_req_valid | input | 1 | User issues a request |
| usr_req_data | input | DW | User request word (address, command, write data) |
| mem_req_valid | output | 1 | Request presented to the memory pipeline |
| mem_req_data | output | DW | Request word to the memory pipeline |
| mem_rd_valid | input | 1 | Memory pipeline returns a read word |
| mem_rd_data | input | RW | Returned read word |
| usr_rd_valid | output | 1 | Read word delivered to the user |
| usr_rd_data | output | RW | Read word to the user |
| ovf_err | output | 1 | One-cycle pulse: an entry was dropped at a full queue |

## Verification
A corrupted pointer or count shows up at the ports on the first cycle after hold falls. At that point the wrong word, a repeated word, or a missing valid appears on mem_req_data or usr_rd_data. A count that fails to track a simultaneous push and pop makes traffic bypass the queue too early, which reorders the stream within a few cycles. It can also raise a false ovf_err one cycle after the bad push. A leak through the hold gating is visible in the same cycle as a valid on the blocked side.

// File: rtl/stall_buffer.sv
module stall_buffer #(
  parameter int DW        = 16,
  parameter int RW        = 32,
  parameter int STALL_LAT = 2,
  parameter int PIPE_LAT  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          usr_req_valid,
  input  logic [DW-1:0] usr_req_data,
  output logic          mem_req_valid,
  output logic [DW-1:0] mem_req_data,
  input  logic          mem_rd_valid,
  input  logic [RW-1:0] mem_rd_data,
  output logic          usr_rd_valid,
  output logic [RW-1:0] usr_rd_data,
  output logic          ovf_err
);

  localparam int IN_DEPTH  = STALL_LAT;
  localparam int OUT_DEPTH = PIPE_LAT + STALL_LAT;
  localparam int IAW = (IN_DEPTH  > 1) ? $clog2(IN_DEPTH)  : 1;
  localparam int OAW = (OUT_DEPTH > 1) ? $clog2(OUT_DEPTH) : 1;
  localparam int ICW = $clog2(IN_DEPTH + 1);
  localparam int OCW = $clog2(OUT_DEPTH + 1);
  localparam logic [IAW-1:0] IN_LAST  = IAW'(IN_DEPTH - 1);
  localparam logic [OAW-1:0] OUT_LAST = OAW'(OUT_DEPTH - 1);
  localparam logic [ICW-1:0] IN_FULL  = ICW'(IN_DEPTH);
  localparam logic [OCW-1:0] OUT_FULL = OCW'(OUT_DEPTH);

  logic [DW-1:0]  in_mem  [IN_DEPTH];
  logic [RW-1:0]  out_mem [OUT_DEPTH];
  logic [IAW-1:0] in_wp, in_rp;
  logic [OAW-1:0] out_wp, out_rp;
  logic [ICW-1:0] in_cnt;
  logic [OCW-1:0] out_cnt;

  logic in_has, out_has, in_full, out_full;
  logic in_push, in_pop, in_take, out_push, out_pop, out_take;

  assign in_has   = in_cnt  != '0;
  assign out_has  = out_cnt != '0;
  assign in_full  = in_cnt  == IN_FULL;
  assign out_full = out_cnt == OUT_FULL;

  assign in_pop   = !hold && in_has;
  assign in_push  = usr_req_valid && (hold || in_has);
  assign in_take  = in_push && (!in_full || in_pop);

  assign out_pop  = !hold && out_has;
  assign out_push = mem_rd_valid && (hold || out_has);
  assign out_take = out_push && (!out_full || out_pop);

  assign mem_req_valid = !hold && (in_has || usr_req_valid);
  assign mem_req_data  = in_has ? in_mem[in_rp] : usr_req_data;
  assign usr_rd_valid  = !hold && (out_has || mem_rd_valid);
  assign usr_rd_data   = out_has ? out_mem[out_rp] : mem_rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_wp  <= '0;
      in_rp  <= '0;
      in_cnt <= '0;
    end else begin
      if (in_take) begin
        in_mem[in_wp] <= usr_req_data;
        in_wp <= (in_wp == IN_LAST) ? '0 : in_wp + 1'b1;
      end
      if (in_pop)
        in_rp <= (in_rp == IN_LAST) ? '0 : in_rp + 1'b1;
      case ({in_take, in_pop})
        2'b10:   in_cnt <= in_cnt + 1'b1;
        2'b01:   in_cnt <= in_cnt - 1'b1;
        default: in_cnt <= in_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_wp  <= '0;
      out_rp  <= '0;
      out_cnt <= '0;
    end else begin
      if (out_take) begin
        out_mem[out_wp] <= mem_rd_data;
        out_wp <= (out_wp == OUT_LAST) ? '0 : out_wp + 1'b1;
      end
      if (out_pop)
        out_rp <= (out_rp == OUT_LAST) ? '0 : out_rp + 1'b1;
      case ({out_take, out_pop})
        2'b10:   out_cnt <= out_cnt + 1'b1;
        2'b01:   out_cnt <= out_cnt - 1'b1;
        default: out_cnt <= out_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_err <= 1'b0;
    else        ovf_err <= (in_push && !in_take) || (out_push && !out_take);
  end

endmodule

module stall_buffer_chk #(
  parameter int DW        = 16,
  parameter int ICW       = 2,
  parameter int OCW       = 4,
  parameter int IN_DEPTH  = 2,
  parameter int OUT_DEPTH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hold,
  input logic           usr_req_valid,
  input logic [DW-1:0]  usr_req_data,
  input logic           mem_req_valid,
  input logic [DW-1:0]  mem_req_data,
  input logic           usr_rd_valid,
  input logic [ICW-1:0] in_cnt,
  input logic [OCW-1:0] out_cnt
);

  // R3
  hold_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !mem_req_valid);

  // R4
  hold_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !usr_rd_valid);

  // R2
  pass_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && in_cnt == '0 && usr_req_valid) |-> (mem_req_valid && mem_req_data == usr_req_data));

  // R7
  in_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(in_cnt) <= IN_DEPTH);

  // R7
  out_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(out_cnt) <= OUT_DEPTH);

  // R5
  in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && in_cnt != '0) |-> mem_req_valid ##1 (in_cnt <= $past(in_cnt)));

  // R6
  out_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && out_cnt != '0) |-> usr_rd_valid ##1 (out_cnt <= $past(out_cnt)));

endmodule

bind stall_buffer stall_buffer_chk #(
  .DW(DW), .ICW(ICW), .OCW(OCW), .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold),
  .usr_req_valid(usr_req_valid), .usr_req_data(usr_req_data),
  .mem_req_valid(mem_req_valid), .mem_req_data(mem_req_data),
  .usr_rd_valid(usr_rd_valid), .in_cnt(in_cnt), .out_cnt(out_cnt)
);

// File: tb/stall_buffer_tb.sv
module stall_buffer_tb;
  localparam int DW = 16;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold = 1'b0;
  logic          usr_req_valid = 1'b0;
  logic [DW-1:0] usr_req_data = '0;
  logic          mem_req_valid;
  logic [DW-1:0] mem_req_data;
  logic          mem_rd_valid = 1'b0;
  logic [RW-1:0] mem_rd_data = '0;
  logic          usr_rd_valid;
  logic [RW-1:0] usr_rd_data;
  logic          ovf_err;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  stall_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .usr_req_valid(usr_req_valid), .usr_req_data(usr_req_data),
    .mem_req_valid(mem_req_valid), .mem_req_data(mem_req_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .usr_rd_valid(usr_rd_valid), .usr_rd_data(usr_rd_data),
    .ovf_err(ovf_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expect_req(input string req, input bit v, input logic [DW-1:0] d);
    check(mem_req_valid == v && (!v || mem_req_data == d), req,
          {mem_req_valid, 16'h0, mem_req_data}, {v, 16'h0, d});
  endtask

  task automatic expect_rd(input string req, input bit v, input logic [RW-1:0] d);
    check(usr_rd_valid == v && (!v || usr_rd_data == d), req,
          {usr_rd_valid, 16'h0, usr_rd_data}, {v, 16'h0, d});
  endtask

  task automatic next();
    @(negedge clk);
    usr_req_valid = 1'b0;
    mem_rd_valid  = 1'b0;
  endtask

  task automatic t_reset();
    #2;
    expect_req("R1", 1'b0, '0);
    expect_rd("R1", 1'b0, '0);
    check(ovf_err == 1'b0, "R1", 64'(ovf_err), 64'd0);
  endtask

  task automatic t_pass();
    usr_req_valid = 1'b1; usr_req_data = 16'h1234;
    mem_rd_valid = 1'b1;  mem_rd_data = 32'hCAFE0001;
    #2;
    expect_req("R2", 1'b1, 16'h1234);
    expect_rd("R2", 1'b1, 32'hCAFE0001);
    next();
  endtask

  task automatic t_req_hold();
    hold = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (i < 2) begin usr_req_valid = 1'b1; usr_req_data = 16'hA000 + 16'(i); end
      #2;
      expect_req("R3", 1'b0, '0);
      next();
    end
    hold = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (i < 2) begin usr_req_valid = 1'b1; usr_req_data = 16'hB000 + 16'(i); end
      #2;
      case (i)
        0: expect_req("R5", 1'b1, 16'hA000);
        1: expect_req("R5", 1'b1, 16'hA001);
        2: expect_req("R5", 1'b1, 16'hB000);
        3: expect_req("R5", 1'b1, 16'hB001);
        default: expect_req("R5", 1'b0, '0);
      endcase
      if (i > 0) check(ovf_err == 1'b0, "R9", 64'(ovf_err), 64'd0);
      next();
    end
  endtask

  task automatic t_rd_hold();
    hold = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (i < 8) begin mem_rd_valid = 1'b1; mem_rd_data = 32'hD0D0_0000 + 32'(i); end
      #2;
      expect_rd("R4", 1'b0, '0);
      if (i > 0) check(ovf_err == 1'b0, "R7", 64'(ovf_err), 64'd0);
      next();
    end
    hold = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (i == 0) begin mem_rd_valid = 1'b1; mem_rd_data = 32'hE0E0_0008; end
      #2;
      if (i < 8)       expect_rd("R6", 1'b1, 32'hD0D0_0000 + 32'(i));
      else if (i == 8) expect_rd("R6", 1'b1, 32'hE0E0_0008);
      else             expect_rd("R6", 1'b0, '0);
      check(ovf_err == 1'b0, "R7", 64'(ovf_err), 64'd0);
      next();
    end
  endtask

  task automatic t_ovf();
    hold = 1'b1;
    for (int i = 0; i < 3; i++) begin
      usr_req_valid = 1'b1; usr_req_data = 16'hC000 + 16'(i);
      #2;
      check(ovf_err == 1'b0, "R8", 64'(ovf_err), 64'd0);
      next();
    end
    #2;
    check(ovf_err == 1'b1, "R8", 64'(ovf_err), 64'd1);
    next();
    #2;
    check(ovf_err == 1'b0, "R8", 64'(ovf_err), 64'd0);
    hold = 1'b0;
    #2;
    expect_req("R8", 1'b1, 16'hC000);
    next();
    #2;
    expect_req("R8", 1'b1, 16'hC001);
    next();
    #2;
    expect_req("R8", 1'b0, '0);
    next();
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    next();
    t_pass();
    t_req_hold();
    t_rd_hold();
    t_ovf();
    t_pass();
    finish_run();
  end
endmodule